// File: doc/BRIEF.md
# Divided One-Shot and Periodic Down-Counter Timer

This block is a 32-bit local timer that counts down from a programmed start value at a rate derived from the core clock by a selectable power-of-two divider. Software programs it through a simple 32-bit register port. It sets the start value, picks the clock divider and chooses between a single expiry and a repeating expiry. When the count runs out, the block raises a one-cycle pulse that an interrupt dispatcher turns into a timer interrupt.

Writing the start value arms the timer and restarts the divider phase at once. A start value of zero keeps the timer fully inert. In single-expiry mode the timer halts at zero and stays silent until software writes a new start value. In repeating mode the count reloads at expiry, so the pulses keep coming at a fixed period.

Top module: `div_timer`

## Requirements
- R1: After reset the start-value, live-count, divider and control registers all read zero and `fire_o` is low.
- R2: A write to the start-value register (offset 0x380) loads both the start value and the live count (offset 0x390). Both read back as the written value in the cycle after the write edge.
- R3: While the start value is zero the live count does not change and `fire_o` never asserts. Writing zero to a running timer stops it.
- R4: The divider code is formed from bits {3,1,0} of the divider register (offset 0x3E0). Codes 000 to 110 divide by 2, 4, 8, 16, 32, 64 and 128, and code 111 divides by 1. The live count drops by one every N clocks, with the first drop N clocks after the write edge of the start-value or divider register.
- R5: `fire_o` is high for exactly one cycle, the cycle after the clock edge at which the count expires. At divide-by-1 with start value 1 in repeating mode, this means a pulse on every cycle.
- R6: With bit 17 of the control register (offset 0x320) at 0 (single expiry), the live count reads 0 after expiry and holds there. No further pulse occurs until the start value is written again.
- R7: With bit 17 of the control register at 1 (repeating), the live count reloads to the start value at the expiring tick instead of passing through zero. A pulse is emitted every start-value × N clocks.
- R8: Reads of any offset other than 0x320, 0x380, 0x390 and 0x3E0 return zero. Writes to such offsets change no register.
- R9: The live-count register is read-only: a write to offset 0x390 leaves it unchanged.
- R10: The divider register keeps only bits 3, 1 and 0. All other bits read back zero, and the control register reads back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 12 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| fire_o | output | 1 | One-cycle expiry pulse toward the interrupt dispatcher |

## Verification
The assertions check the following on every cycle:
- the count moves only on a divided tick and then by exactly one;
- an expired single-expiry count holds at zero;
- a repeating count reloads with a pulse;
- a zero start value suppresses the pulse;
- the divider phase restarts after a write.

Only the directed scenarios can show the absolute rates for each divider code, the exact cycle of the first and later pulses, the silence after a single expiry until a rewrite, and the handling of read-only and unmapped offsets.

// File: rtl/div_timer_pkg.sv
package div_timer_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned PRE_W   = 7;   // covers divide-by-128
  localparam int unsigned MODE_BIT = 17;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 12'h320;
  localparam logic [ADDR_W-1:0] OFF_START = 12'h380;
  localparam logic [ADDR_W-1:0] OFF_LIVE  = 12'h390;
  localparam logic [ADDR_W-1:0] OFF_DIV   = 12'h3E0;

  // code 111 -> /1, otherwise /2^(code+1)
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    return (code == 3'b111) ? '0 : SHIFT_W'(code + 3'd1);
  endfunction
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import div_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  live_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [DATA_W-1:0]  start_o,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               periodic_o,
  output logic               load_o,
  output logic               restart_o
);
  logic [DATA_W-1:0] ctrl_q, start_q;
  logic [2:0]        code_q;

  logic wr_start, wr_div, wr_ctrl;
  assign wr_start = we_i && (addr_i == OFF_START);
  assign wr_div   = we_i && (addr_i == OFF_DIV);
  assign wr_ctrl  = we_i && (addr_i == OFF_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      start_q <= '0;
      code_q  <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata_i;
      if (wr_start) start_q <= wdata_i;
      if (wr_div)   code_q  <= {wdata_i[3], wdata_i[1], wdata_i[0]};
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFF_CTRL:  rdata_o = ctrl_q;
      OFF_START: rdata_o = start_q;
      OFF_LIVE:  rdata_o = live_i;
      OFF_DIV:   rdata_o[3:0] = {code_q[2], 1'b0, code_q[1:0]};
      default:   rdata_o = '0;
    endcase
  end

  assign start_o    = start_q;
  assign shift_o    = code_to_shift(code_q);
  assign periodic_o = ctrl_q[MODE_BIT];
  assign load_o     = wr_start;
  assign restart_o  = wr_start || wr_div;

  p_load_value_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (start_o == $past(wdata_i)));
  p_div_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_div |=> (shift_o == code_to_shift({$past(wdata_i[3]), $past(wdata_i[1]), $past(wdata_i[0])})));
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import div_timer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] cnt_q, mask;

  assign mask   = ~({PRE_W{1'b1}} << shift_i);
  assign tick_o = ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else                cnt_q <= cnt_q + 1'b1;
  end

  // phase restarts: no tick right after a restart unless dividing by 1
  p_restart_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (tick_o == (shift_i == '0)));
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic [DATA_W-1:0] start_i,
  input  logic              periodic_i,
  output logic [DATA_W-1:0] live_o,
  output logic              fire_o
);
  logic [DATA_W-1:0] live_q;
  logic              fire_q, active, last;

  assign active = (start_i != '0) && (live_q != '0);
  assign last   = (live_q == DATA_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load_i) begin
        live_q <= load_val_i;
      end else if (tick_i && active) begin
        if (last) begin
          fire_q <= 1'b1;
          live_q <= periodic_i ? start_i : '0;
        end else begin
          live_q <= live_q - 1'b1;
        end
      end
    end
  end

  assign live_o = live_q;
  assign fire_o = fire_q;

  p_zero_start_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i == '0) |=> !fire_o);
  p_hold_no_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(live_o));
  p_step_one_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && (start_i != '0) && (live_o > DATA_W'(1))) |=> (live_o == $past(live_o) - 1'b1));
  p_oneshot_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (live_o == '0)) |=> ((live_o == '0) && !fire_o));
  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && periodic_i && (start_i != '0) && (live_o == DATA_W'(1)))
      |=> (fire_o && (live_o == $past(start_i))));
endmodule

// File: rtl/div_timer.sv
module div_timer
  import div_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fire_o
);
  logic [DATA_W-1:0]  live, start;
  logic [SHIFT_W-1:0] shift;
  logic               periodic, load, restart, tick;

  timer_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .live_i(live), .rdata_o, .start_o(start), .shift_o(shift),
    .periodic_o(periodic), .load_o(load), .restart_o(restart)
  );

  timer_prescaler u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .shift_i(shift), .tick_o(tick)
  );

  timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(load), .load_val_i(wdata_i),
    .start_i(start), .periodic_i(periodic), .live_o(live), .fire_o
  );

  p_live_readonly_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == OFF_LIVE) && !tick) |=> $stable(live));
endmodule

// File: tb/div_timer_tb.sv
module div_timer_tb;
  localparam time CLK_P = 10ns;
  localparam logic [11:0] A_CTRL = 12'h320, A_START = 12'h380,
                          A_LIVE = 12'h390, A_DIV = 12'h3E0;

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        fire;
  int checks = 0, errors = 0, fire_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  div_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .fire_o(fire)
  );

  always @(negedge clk) if (rst_n && fire) fire_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); #1;
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic step(int m);
    repeat (m) @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_START, v); chk("R1 start", v, 0);
    rd(A_LIVE, v);  chk("R1 live", v, 0);
    rd(A_DIV, v);   chk("R1 div", v, 0);
    rd(A_CTRL, v);  chk("R1 ctrl", v, 0);
    chk("R1 fire", fire, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(A_DIV, 32'hFFFF_FFFF);
    rd(A_DIV, v); chk("R10 div bits", v, 32'h0000_000B);
    wr(A_CTRL, 32'h0002_0000);
    rd(A_CTRL, v); chk("R10 ctrl readback", v, 32'h0002_0000);
    wr(A_CTRL, 32'h0);
    wr(12'h3F0, 32'h1234_5678);
    rd(12'h3F0, v); chk("R8 unmapped read", v, 0);
    rd(A_START, v); chk("R8 unmapped write no effect", v, 0);
    wr(A_DIV, 32'h0000_000A);          // /128
    wr(A_START, 32'd9);
    rd(A_START, v); chk("R2 start loaded", v, 9);
    rd(A_LIVE, v);  chk("R2 live loaded", v, 9);
    wr(A_LIVE, 32'd77);
    rd(A_LIVE, v);  chk("R9 live read-only", v, 9);
    wr(A_START, 32'd0);
  endtask

  task automatic t_rate(logic [31:0] dv, int n);
    logic [31:0] v;
    wr(A_DIV, dv);
    wr(A_START, 32'd3);
    step(n - 1); rd(A_LIVE, v); chk($sformatf("R4 /%0d before tick", n), v, 3);
    step(1);     rd(A_LIVE, v); chk($sformatf("R4 /%0d first tick", n), v, 2);
    step(n);     rd(A_LIVE, v); chk($sformatf("R4 /%0d second tick", n), v, 1);
    wr(A_START, 32'd0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_DIV, 32'h0000_000B);          // /1
    fire_cnt = 0;
    wr(A_START, 32'd4);
    step(3); chk("R5 no early fire", fire, 0);
    rd(A_LIVE, v); chk("R4 live before expiry", v, 1);
    step(1); chk("R5 fire at expiry", fire, 1);
    rd(A_LIVE, v); chk("R6 live zero after expiry", v, 0);
    step(1); chk("R5 single-cycle pulse", fire, 0);
    step(30); chk("R6 no refire", fire_cnt, 1);
    rd(A_LIVE, v); chk("R6 live holds zero", v, 0);
    wr(A_START, 32'd2);
    step(2); chk("R6 rearm by rewrite", fire, 1);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(A_CTRL, 32'h0002_0000);
    wr(A_DIV, 32'h0);                  // /2
    fire_cnt = 0;
    wr(A_START, 32'd3);
    step(5); chk("R7 no early fire", fire, 0);
    step(1); chk("R7 first period fire", fire, 1);
    rd(A_LIVE, v); chk("R7 reload value", v, 3);
    step(6); chk("R7 second period fire", fire, 1);
    step(6); chk("R7 pulse count", fire_cnt, 3);
    wr(A_START, 32'd0);
    fire_cnt = 0;
    step(40); chk("R3 stopped by zero start", fire_cnt, 0);
    rd(A_LIVE, v); chk("R3 live stays zero", v, 0);
    wr(A_DIV, 32'h0000_000B);
    wr(A_START, 32'd1);
    fire_cnt = 0;
    step(5); chk("R5 /1 start 1 fires every cycle", fire_cnt, 5);
    wr(A_START, 32'd0);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_regmap();
    t_rate(32'h0000_000B, 1);
    t_rate(32'h0000_0000, 2);
    t_rate(32'h0000_0003, 16);
    t_rate(32'h0000_0008, 32);
    t_rate(32'h0000_000A, 128);
    t_oneshot();
    t_periodic();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule